// File: doc/BRIEF.md
# Bloom Table-Select Prefilter

This block sits in front of a multi-table packet classifier. It takes a short key built from one or two exact-match header fields, for example the 3-bit VLAN priority joined with the 6-bit IP type-of-service. It computes two independent hash indices from the key and tests them against a Bloom filter bit vector. If both bits are set, the key may be in the rule set. The block then reads one table-select bitmap per hash from two bitmap stores and keeps only the tables that both bitmaps name. It then ORs in a per-node wildcard mask. The result is a small bitmap that tells the classifier which downstream hash tables to probe.

A miss in the filter skips the bitmap stores. In that case the result is the wildcard mask alone, because only rules that wildcard the field can still match. The filter may report false positives but never false negatives. A host loads the filter bits, both bitmap stores and the wildcard mask through one address/data port. Lookups are refused in any cycle that carries a host write.

Queries enter through a valid/ready handshake and leave through one. The block is a two-stage pipeline that accepts one query per cycle and stalls as a whole when the output is not taken.

Top module: `bloom_tsel_prefilter`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, every filter bit is 0 and the wildcard mask is 0, so a first query returns out_hit=0 and out_tsel=0.
- R2: With IDX_W = log2(FILTER_BITS), hash A is (k XOR (k >> IDX_W)) mod FILTER_BITS and hash B is (k*HASH2_MULT + (k >> IDX_W)) mod FILTER_BITS (defaults: IDX_W=7, HASH2_MULT=77). out_hit is 1 only when the filter bits at both indices are 1. If only one of the two bits is set, the query misses.
- R3: On a hit, out_tsel = (storeA[hashA] AND storeB[hashB]) OR mask. The most significant bit of out_tsel stands for table 0, so 1011 AND 1100 with a zero mask gives 1000, which selects table 0 alone.
- R4: On a miss, out_tsel equals the wildcard mask, whatever the bitmap stores hold.
- R5: A key whose two filter bits have both been written to 1 always reports out_hit=1 (no false negatives).
- R6: Host writes use cfg_sel codes 0 = filter bit (value cfg_wdata[0] at cfg_addr), 1 = bitmap store A entry, 2 = bitmap store B entry, 3 = wildcard mask (cfg_addr ignored). in_ready is 0 in every cycle in which cfg_we is 1.
- R7: With out_ready held at 1, a query accepted at a rising edge shows out_valid=1 after the second rising edge that follows. Results leave in acceptance order, one per accepted query.
- R8: While out_valid=1 and out_ready=0, out_valid, out_hit and out_tsel stay unchanged and in_ready is 0.
- R9: A query sees the filter, the bitmaps and the mask as they stood at its acceptance edge. Host writes made while the query is in flight do not change its result.
- R10: Writing 0 to a filter bit takes effect for the next query, so a key that hit before now misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Host write strobe |
| cfg_sel | input | 2 | Host write target (0 filter, 1 store A, 2 store B, 3 mask) |
| cfg_addr | input | IDX_W | Filter bit or bitmap entry index |
| cfg_wdata | input | TABLES | Write data (bit 0 only for the filter) |
| in_valid | input | 1 | Query valid |
| in_ready | output | 1 | Query accepted when high with in_valid |
| in_key | input | KEY_W | Query key |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result taken when high with out_valid |
| out_hit | output | 1 | Bloom filter hit |
| out_tsel | output | TABLES | Table-select bitmap, MSB = table 0 |

## Verification
The assertions check, on every cycle, the handshake rules: no query is accepted alongside a host write, a stalled result holds steady with in_ready low, each new result follows an occupied first stage, and a filter write lands in the addressed bit. The bench's scenarios show the data path itself: the hash-index placement, the AND of the two bitmaps with the table-0-on-the-left order, the mask fallback on a miss, the absence of false negatives over a batch of inserted keys, and the snapshot of configuration at acceptance. A scoreboard fed from a reference model compares every result in order, including under random output back-pressure.

// File: rtl/bpf_pkg.sv
package bpf_pkg;
  typedef enum logic [1:0] {
    CFG_FILTER = 2'd0,
    CFG_MAP_A  = 2'd1,
    CFG_MAP_B  = 2'd2,
    CFG_MASK   = 2'd3
  } cfg_sel_e;

  localparam int NUM_HASH = 2;
endpackage

// File: rtl/bpf_hash.sv
module bpf_hash #(
  parameter int KEY_W   = 9,
  parameter int IDX_W   = 7,
  parameter int VARIANT = 0,
  parameter int MULT    = 77,
  parameter int MULT_W  = 8
) (
  input  logic [KEY_W-1:0] key,
  output logic [IDX_W-1:0] idx
);
  localparam int PW = KEY_W + MULT_W;

  logic [KEY_W-1:0] fold;
  assign fold = key >> IDX_W;

  generate
    if (VARIANT == 0) begin : g_xor_fold
      assign idx = IDX_W'(key ^ fold);
    end else begin : g_mult_fold
      logic [PW-1:0] prod;
      assign prod = PW'(key) * PW'(MULT);
      assign idx  = IDX_W'(prod + PW'(fold));
    end
  endgenerate
endmodule

// File: rtl/bpf_filter_bits.sv
module bpf_filter_bits #(
  parameter int FILTER_BITS = 128,
  parameter int NRD         = 2,
  localparam int IDX_W      = $clog2(FILTER_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic             wbit,
  input  logic [IDX_W-1:0] raddr [NRD],
  output logic             rbit  [NRD]
);
  logic [FILTER_BITS-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q <= '0;
    end else if (we) begin
      bits_q[waddr] <= wbit;
    end
  end

  generate
    for (genvar g = 0; g < NRD; g++) begin : g_rd
      assign rbit[g] = bits_q[raddr[g]];
    end
  endgenerate

  // R10: a write lands in the addressed bit by the next cycle
  a_r10_bit_written: assert property (@(posedge clk) disable iff (rst)
    we |=> bits_q[$past(waddr)] == $past(wbit));
endmodule

// File: rtl/bpf_map_ram.sv
module bpf_map_ram #(
  parameter int DEPTH  = 128,
  parameter int WIDTH  = 4,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (re) begin
      rdata <= mem[raddr];
    end
  end
endmodule

// File: rtl/bloom_tsel_prefilter.sv
module bloom_tsel_prefilter
  import bpf_pkg::*;
#(
  parameter int KEY_W       = 9,
  parameter int FILTER_BITS = 128,
  parameter int TABLES      = 4,
  parameter int HASH2_MULT  = 77,
  localparam int IDX_W      = $clog2(FILTER_BITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [IDX_W-1:0]  cfg_addr,
  input  logic [TABLES-1:0] cfg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [KEY_W-1:0]  in_key,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_hit,
  output logic [TABLES-1:0] out_tsel
);
  // Pipeline control: the whole pipe advances together
  logic advance;
  logic accept;

  assign advance  = !out_valid || out_ready;
  assign in_ready = advance && !cfg_we;
  assign accept   = in_valid && in_ready;

  // Hash indices
  logic [IDX_W-1:0] hidx [NUM_HASH];

  generate
    for (genvar g = 0; g < NUM_HASH; g++) begin : g_hash
      bpf_hash #(
        .KEY_W  (KEY_W),
        .IDX_W  (IDX_W),
        .VARIANT(g),
        .MULT   (HASH2_MULT)
      ) u_hash (
        .key(in_key),
        .idx(hidx[g])
      );
    end
  endgenerate

  // Bloom filter bit vector
  logic fbit [NUM_HASH];
  logic filt_we;

  assign filt_we = cfg_we && (cfg_sel == CFG_FILTER);

  bpf_filter_bits #(
    .FILTER_BITS(FILTER_BITS),
    .NRD        (NUM_HASH)
  ) u_filter (
    .clk  (clk),
    .rst  (rst),
    .we   (filt_we),
    .waddr(cfg_addr),
    .wbit (cfg_wdata[0]),
    .raddr(hidx),
    .rbit (fbit)
  );

  logic probe_hit;
  assign probe_hit = fbit[0] && fbit[1];

  // Bitmap stores: read only when the probe hits
  logic [TABLES-1:0] map_q [NUM_HASH];
  logic              map_re;

  assign map_re = accept && probe_hit;

  generate
    for (genvar g = 0; g < NUM_HASH; g++) begin : g_map
      logic map_we;
      assign map_we = cfg_we && (cfg_sel == (2'(g) + CFG_MAP_A));

      bpf_map_ram #(
        .DEPTH(FILTER_BITS),
        .WIDTH(TABLES)
      ) u_map (
        .clk  (clk),
        .we   (map_we),
        .waddr(cfg_addr),
        .wdata(cfg_wdata),
        .re   (map_re),
        .raddr(hidx[g]),
        .rdata(map_q[g])
      );
    end
  endgenerate

  // Wildcard mask
  logic [TABLES-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
    end else if (cfg_we && (cfg_sel == CFG_MASK)) begin
      mask_q <= cfg_wdata;
    end
  end

  // Stage A: probe result and mask snapshot
  logic              a_valid;
  logic              a_hit;
  logic [TABLES-1:0] a_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_valid <= 1'b0;
      a_hit   <= 1'b0;
      a_mask  <= '0;
    end else if (advance) begin
      a_valid <= accept;
      if (accept) begin
        a_hit  <= probe_hit;
        a_mask <= mask_q;
      end
    end
  end

  // Stage B: combine and register outputs
  logic [TABLES-1:0] both_maps;
  logic [TABLES-1:0] tsel_next;

  always_comb begin
    both_maps = map_q[0];
    for (int i = 1; i < NUM_HASH; i++) begin
      both_maps = both_maps & map_q[i];
    end
    tsel_next = a_hit ? (both_maps | a_mask) : a_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_tsel  <= '0;
    end else if (advance) begin
      out_valid <= a_valid;
      if (a_valid) begin
        out_hit  <= a_hit;
        out_tsel <= tsel_next;
      end
    end
  end

  // R6: no query enters in a host write cycle
  a_r6_no_accept_on_write: assert property (@(posedge clk) disable iff (rst)
    cfg_we |-> !accept);

  // R8: a stalled result holds steady
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_tsel) && $stable(out_hit)));

  // R8: no intake while the output is stalled
  a_r8_no_intake_stalled: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R7: a new result follows an occupied first stage
  a_r7_result_from_stage: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(a_valid));
endmodule

// File: tb/bloom_tsel_prefilter_tb.sv
module bloom_tsel_prefilter_tb;
  localparam int KEY_W  = 9;
  localparam int FB     = 128;
  localparam int IDX_W  = 7;
  localparam int TABLES = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_we = 1'b0;
  logic [1:0]        cfg_sel = '0;
  logic [IDX_W-1:0]  cfg_addr = '0;
  logic [TABLES-1:0] cfg_wdata = '0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [KEY_W-1:0]  in_key = '0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic              out_hit;
  logic [TABLES-1:0] out_tsel;

  always #4 clk = ~clk;

  bloom_tsel_prefilter u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready), .in_key(in_key),
    .out_valid(out_valid), .out_ready(out_ready), .out_hit(out_hit), .out_tsel(out_tsel)
  );

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic              hit;
    logic [TABLES-1:0] tsel;
    string             tag;
  } exp_t;

  exp_t sb[$];

  // Reference model
  bit                filt  [FB];
  logic [TABLES-1:0] map_a [FB];
  logic [TABLES-1:0] map_b [FB];
  logic [TABLES-1:0] mask_m = '0;

  function automatic int ha(int k);
    return (k ^ (k >> IDX_W)) & (FB - 1);
  endfunction

  function automatic int hb(int k);
    return (k * 77 + (k >> IDX_W)) & (FB - 1);
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cfg_write(int sel, int addr, int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_addr = IDX_W'(addr); cfg_wdata = TABLES'(data);
    #1;
    check(in_ready == 1'b0, "R6", "in_ready during write", int'(in_ready), 0);
    case (sel)
      0: filt[addr]  = data[0];
      1: map_a[addr] = TABLES'(data);
      2: map_b[addr] = TABLES'(data);
      default: mask_m = TABLES'(data);
    endcase
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic send(int k, exp_t e);
    @(negedge clk);
    in_valid = 1'b1; in_key = KEY_W'(k);
    #1;
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    sb.push_back(e);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic query(int k, string tag);
    exp_t e;
    e.hit  = filt[ha(k)] && filt[hb(k)];
    e.tsel = e.hit ? ((map_a[ha(k)] & map_b[hb(k)]) | mask_m) : mask_m;
    e.tag  = tag;
    send(k, e);
  endtask

  task automatic query_lit(int k, logic hit, logic [TABLES-1:0] tsel, string tag);
    exp_t e;
    e.hit = hit; e.tsel = tsel; e.tag = tag;
    send(k, e);
  endtask

  task automatic drain();
    out_ready = 1'b1;
    repeat (200) begin
      @(negedge clk);
      if (sb.size() == 0) break;
    end
    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R7", "pending results", sb.size(), 0);
  endtask

  // Monitor / scoreboard
  logic              prev_stall = 1'b0;
  logic              prev_hit;
  logic [TABLES-1:0] prev_tsel;

  initial begin
    forever begin
      @(negedge clk); #2;
      if (!rst) begin
        if (prev_stall) begin
          check(out_valid && out_hit == prev_hit && out_tsel == prev_tsel, "R8",
                "stalled tsel", int'(out_tsel), int'(prev_tsel));
        end
        if (out_valid && !out_ready) begin
          check(in_ready == 1'b0, "R8", "in_ready while stalled", int'(in_ready), 0);
        end
        if (out_valid && out_ready) begin
          if (sb.size() == 0) begin
            check(1'b0, "R7", "unexpected result", 1, 0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            check(out_hit == e.hit, e.tag, "hit", int'(out_hit), int'(e.hit));
            check(out_tsel == e.tsel, e.tag, "tsel", int'(out_tsel), int'(e.tsel));
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_hit   = out_hit;
        prev_tsel  = out_tsel;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < FB; i++) begin
      filt[i] = 1'b0; map_a[i] = '0; map_b[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk); #1;
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

    // R1: empty filter, zero mask
    query_lit(5, 1'b0, 4'b0000, "R1");
    drain();

    // Load both bitmap stores with varied patterns
    for (int i = 0; i < FB; i++) begin
      cfg_write(1, i, (i * 3) & 15);
      cfg_write(2, i, (i * 7 + 5) & 15);
    end

    // R2: key 5 -> hash A 5, hash B 1; only one bit set -> miss
    cfg_write(0, 5, 1);
    query_lit(5, 1'b0, 4'b0000, "R2");
    cfg_write(0, 1, 1);
    // R3: 1011 AND 1100 -> 1000 (table 0 only)
    cfg_write(1, 5, 4'b1011);
    cfg_write(2, 1, 4'b1100);
    query_lit(5, 1'b1, 4'b1000, "R3");
    // R3: mask ORed in on a hit
    cfg_write(3, 0, 4'b0001);
    query_lit(5, 1'b1, 4'b1001, "R3");
    drain();

    // R7: latency with free output
    begin
      @(negedge clk); in_valid = 1'b1; in_key = 9'd5; #1;
      sb.push_back('{1'b1, 4'b1001, "R7"});
      @(posedge clk); #1 in_valid = 1'b0;
      @(negedge clk); #1;
      check(out_valid == 1'b0, "R7", "out_valid one edge after accept", int'(out_valid), 0);
      @(negedge clk); #1;
      check(out_valid == 1'b1, "R7", "out_valid two edges after accept", int'(out_valid), 1);
    end
    drain();

    // R4: miss returns the mask regardless of bitmaps
    cfg_write(3, 0, 4'b0101);
    query_lit(300, 1'b0, 4'b0101, "R4");
    query(300, "R4");
    drain();

    // R5: inserted keys never miss
    for (int i = 0; i < 10; i++) begin
      cfg_write(0, ha(17 * i + 3), 1);
      cfg_write(0, hb(17 * i + 3), 1);
    end
    for (int i = 0; i < 10; i++) begin
      exp_t e;
      e.hit = 1'b1; e.tag = "R5";
      e.tsel = (map_a[ha(17 * i + 3)] & map_b[hb(17 * i + 3)]) | mask_m;
      send(17 * i + 3, e);
    end
    drain();

    // R9: writes after acceptance do not alter an in-flight query
    query_lit(5, 1'b1, 4'b1101, "R9");
    cfg_write(3, 0, 4'b0000);
    cfg_write(1, 5, 4'b0000);
    drain();
    query_lit(5, 1'b1, 4'b0000, "R9");
    drain();

    // R10: clearing a filter bit turns a hit into a miss
    cfg_write(0, 1, 0);
    query_lit(5, 1'b0, 4'b0000, "R10");
    drain();

    // R8: streaming under random back-pressure
    fork
      begin
        for (int i = 0; i < 40; i++) query((i * 29 + 11) & 511, "R8");
      end
      begin
        repeat (90) begin
          @(negedge clk);
          out_ready = 1'($urandom % 2);
        end
        out_ready = 1'b1;
      end
    join
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule